// File: doc/BRIEF.md
# Dual-Space Circular Address Generator

This block produces two data-memory addresses in every clock cycle, one for the X memory space and one for the Y memory space. Each space owns a bank of four pointer registers, four offset registers and four modifier registers, all 11 bits wide. Each bank also owns a small arithmetic unit. In a given cycle, each side selects one of its pointers and a post-modify mode. The selected pointer goes out unchanged as the effective address. The pointer is then written back with its updated value, using either linear arithmetic or circular-buffer arithmetic.

The modifier register of a pointer sets the arithmetic. A modifier of all ones gives plain linear arithmetic, which wraps at 2048. Any other modifier value M defines a circular buffer of length M+1. The base of that buffer is aligned to the next power of two at or above M+1.

A single register port lets other logic write and read every pointer, offset and modifier as general data. A write through this port takes priority over a same-cycle pointer update of the same register.

Top module: `dual_ptr_agu`

## Requirements
- R1: After reset, every pointer and every offset register reads 0, and every modifier register reads 2047 (linear).
- R2: Both spaces operate in the same cycle and independently of each other. The X side (`x_sel`) addresses bank registers 0-3, and the Y side (`y_sel`) addresses registers 4-7. On the register port, bit 2 of `bus_idx` picks the space and bits 1:0 pick the register within it.
- R3: `x_addr` and `y_addr` always equal the selected pointer's value before that cycle's update.
- R4: A side leaves its pointer unchanged in two cases: when its enable is low, or when its mode is 0 (indirect, no update). Mode codes 5 to 7 also act as mode 0.
- R5: With a modifier of 2047, mode 1 adds one to the pointer and mode 2 subtracts one, wrapping modulo 2048 (2047+1 gives 0, and 0-1 gives 2047).
- R6: With a modifier of 2047, mode 3 adds the paired offset register (same index as the pointer) and mode 4 subtracts it, wrapping modulo 2048.
- R7: With a modifier M other than 2047, the buffer length is M+1. The base is the pointer with its low k bits cleared, where k is the smallest value with 2^k > M. If an update rises past base+M, M+1 is subtracted; if it falls below the base, M+1 is added. As long as the step does not exceed M+1, a pointer inside the buffer stays inside it.
- R8: A register-port write to a pointer in the same cycle as an update of that pointer leaves the written value.
- R9: On the register port, `bus_kind` 0 selects pointers, 1 selects offsets and 2 selects modifiers. `bus_rdata` returns the selected register combinationally. Kind 3 reads 0, and a write with kind 3 changes nothing.
- R10: An offset or modifier write in the same cycle as an update takes effect in the next cycle; the update uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_en | input | 1 | X-side update enable |
| x_mode | input | 3 | X-side post-modify mode |
| x_sel | input | 2 | X-side pointer select (bank registers 0-3) |
| x_addr | output | 11 | X-space effective address |
| y_en | input | 1 | Y-side update enable |
| y_mode | input | 3 | Y-side post-modify mode |
| y_sel | input | 2 | Y-side pointer select (bank registers 4-7) |
| y_addr | output | 11 | Y-space effective address |
| bus_wr | input | 1 | Register-port write strobe |
| bus_kind | input | 2 | Register kind: 0 pointer, 1 offset, 2 modifier |
| bus_idx | input | 3 | Register index, bit 2 selects Y space |
| bus_wdata | input | 11 | Register-port write data |
| bus_rdata | output | 11 | Register-port read data |

## Verification
The bound checker watches every cycle for several properties. A held pointer must stay put. A linear increment on X and a linear decrement on Y must each move their pointer by exactly one from the address just issued. A port write to a pointer must always win. Any circular update that starts inside its buffer, with a legal step, must land in the same aligned block and at an offset no larger than the modifier. Other properties only show up in directed and random scenarios checked against an independent model. These are the exact wrap values at both buffer ends, the reset contents, the kind-3 no-op, and the use of old offsets when a write coincides with an update.

// File: rtl/agu_pkg.sv
// Shared encodings for the dual-space address generator.
// Assumes 3-bit mode and 2-bit register-kind fields at the ports.
package agu_pkg;
    typedef enum logic [2:0] {
        AM_HOLD = 3'd0,
        AM_INC  = 3'd1,
        AM_DEC  = 3'd2,
        AM_ADDN = 3'd3,
        AM_SUBN = 3'd4
    } agu_mode_e;

    typedef enum logic [1:0] {
        RK_PTR  = 2'd0,
        RK_OFS  = 2'd1,
        RK_MOD  = 2'd2,
        RK_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/agu_step_alu.sv
// Combinational next-pointer computation for one memory space.
// A modifier of all ones selects linear wrap at 2**AW. Any other value M
// gives a circular buffer of length M+1 whose base is the pointer with the
// bits covered by M's most-significant bit and below cleared.
// Assumes the step does not exceed the buffer length when wrap must be exact.
module agu_step_alu
    import agu_pkg::*;
#(
    parameter int AW = 11,
    localparam int EW = AW + 2
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] ofs,
    input  logic [AW-1:0] modv,
    input  logic [2:0]    mode,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;
    logic          go_up;
    logic          go_dn;
    logic [AW-1:0] mask;
    logic [AW-1:0] base;
    logic [AW-1:0] upper;
    logic [EW-1:0] sum;
    logic [EW-1:0] dif;
    logic [EW-1:0] modulus;
    logic [EW-1:0] sum_w;
    logic [EW-1:0] dif_w;

    // Decode the step size and direction from the mode
    always_comb begin
        step  = '0;
        go_up = 1'b0;
        go_dn = 1'b0;
        case (mode)
            AM_INC:  begin step = AW'(1); go_up = 1'b1; end
            AM_DEC:  begin step = AW'(1); go_dn = 1'b1; end
            AM_ADDN: begin step = ofs;    go_up = 1'b1; end
            AM_SUBN: begin step = ofs;    go_dn = 1'b1; end
            default: begin step = '0; end
        endcase
    end

    // Smear the modifier downward to get the in-buffer offset mask
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            mask[i] = |(modv >> i);
        end
    end

    // Buffer bounds and raw/wrapped candidates
    always_comb begin
        base    = ptr & ~mask;
        upper   = base | modv;
        sum     = {2'b00, ptr} + {2'b00, step};
        dif     = {2'b00, ptr} - {2'b00, step};
        modulus = {2'b00, modv} + EW'(1);
        sum_w   = sum - modulus;
        dif_w   = dif + modulus;
    end

    // Pick the next pointer value
    always_comb begin
        if (!go_up && !go_dn) begin
            nxt = ptr;
        end else if (&modv) begin
            nxt = go_up ? sum[AW-1:0] : dif[AW-1:0];
        end else if (go_up) begin
            nxt = (sum > {2'b00, upper}) ? sum_w[AW-1:0] : sum[AW-1:0];
        end else begin
            nxt = ($signed(dif) < $signed({2'b00, base})) ? dif_w[AW-1:0] : dif[AW-1:0];
        end
    end
endmodule

// File: rtl/agu_space_bank.sv
// One memory space: NPS pointer, offset and modifier registers plus the
// arithmetic unit that updates the selected pointer each cycle.
// A register-port write to a pointer beats a same-cycle update of it.
module agu_space_bank
    import agu_pkg::*;
#(
    parameter int AW  = 11,
    parameter int NPS = 4,
    localparam int SW = $clog2(NPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic [2:0]              upd_mode,
    input  logic [SW-1:0]           upd_sel,
    input  logic                    wr_en,
    input  logic [1:0]              acc_kind,
    input  logic [SW-1:0]           acc_idx,
    input  logic [AW-1:0]           wr_data,
    output logic [AW-1:0]           ea,
    output logic [AW-1:0]           rd_data,
    output logic [NPS-1:0][AW-1:0]  ptr_q,
    output logic [NPS-1:0][AW-1:0]  ofs_q,
    output logic [NPS-1:0][AW-1:0]  mod_q
);
    logic [AW-1:0] nxt;

    agu_step_alu #(.AW(AW)) alu_i (
        .ptr  (ptr_q[upd_sel]),
        .ofs  (ofs_q[upd_sel]),
        .modv (mod_q[upd_sel]),
        .mode (upd_mode),
        .nxt  (nxt)
    );

    // Effective address is the pointer before its update
    assign ea = ptr_q[upd_sel];

    for (genvar g = 0; g < NPS; g++) begin : g_reg
        // Pointer register: reset, port write, then update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (wr_en && acc_kind == RK_PTR && acc_idx == SW'(g)) begin
                ptr_q[g] <= wr_data;
            end else if (upd_en && upd_sel == SW'(g)) begin
                ptr_q[g] <= nxt;
            end
        end

        // Offset register: written only through the port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q[g] <= '0;
            end else if (wr_en && acc_kind == RK_OFS && acc_idx == SW'(g)) begin
                ofs_q[g] <= wr_data;
            end
        end

        // Modifier register: resets to linear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mod_q[g] <= '1;
            end else if (wr_en && acc_kind == RK_MOD && acc_idx == SW'(g)) begin
                mod_q[g] <= wr_data;
            end
        end
    end

    // Register-port read mux
    always_comb begin
        case (acc_kind)
            RK_PTR:  rd_data = ptr_q[acc_idx];
            RK_OFS:  rd_data = ofs_q[acc_idx];
            RK_MOD:  rd_data = mod_q[acc_idx];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dual_ptr_agu.sv
// Top: two space banks side by side, sharing one register port.
// The top bit of bus_idx picks the space; lower bits pick the register.
// Assumes NPS is a power of two.
module dual_ptr_agu #(
    parameter int AW  = 11,
    parameter int NPS = 4,
    localparam int SW = $clog2(NPS),
    localparam int IW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_en,
    input  logic [2:0]    x_mode,
    input  logic [SW-1:0] x_sel,
    output logic [AW-1:0] x_addr,
    input  logic          y_en,
    input  logic [2:0]    y_mode,
    input  logic [SW-1:0] y_sel,
    output logic [AW-1:0] y_addr,
    input  logic          bus_wr,
    input  logic [1:0]    bus_kind,
    input  logic [IW-1:0] bus_idx,
    input  logic [AW-1:0] bus_wdata,
    output logic [AW-1:0] bus_rdata
);
    logic [AW-1:0]              ea_s [2];
    logic [AW-1:0]              rd_s [2];
    logic [2*NPS-1:0][AW-1:0]   ptr_all;
    logic [2*NPS-1:0][AW-1:0]   ofs_all;
    logic [2*NPS-1:0][AW-1:0]   mod_all;

    for (genvar s = 0; s < 2; s++) begin : g_space
        logic          sp_en;
        logic [2:0]    sp_mode;
        logic [SW-1:0] sp_sel;
        logic          sp_wr;

        // Route the side controls and decode the port write for this space
        assign sp_en   = (s == 0) ? x_en   : y_en;
        assign sp_mode = (s == 0) ? x_mode : y_mode;
        assign sp_sel  = (s == 0) ? x_sel  : y_sel;
        assign sp_wr   = bus_wr && (bus_idx[IW-1] == 1'(s));

        agu_space_bank #(.AW(AW), .NPS(NPS)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd_en   (sp_en),
            .upd_mode (sp_mode),
            .upd_sel  (sp_sel),
            .wr_en    (sp_wr),
            .acc_kind (bus_kind),
            .acc_idx  (bus_idx[SW-1:0]),
            .wr_data  (bus_wdata),
            .ea       (ea_s[s]),
            .rd_data  (rd_s[s]),
            .ptr_q    (ptr_all[s*NPS +: NPS]),
            .ofs_q    (ofs_all[s*NPS +: NPS]),
            .mod_q    (mod_all[s*NPS +: NPS])
        );
    end

    // Output addresses and shared read data
    assign x_addr    = ea_s[0];
    assign y_addr    = ea_s[1];
    assign bus_rdata = rd_s[bus_idx[IW-1]];
endmodule

// File: rtl/agu_checker.sv
// Cycle-by-cycle properties of dual_ptr_agu, attached by bind.
// Assumes the register index layout of the top (space bit on top).
module agu_checker #(
    parameter int AW  = 11,
    parameter int NPS = 4,
    localparam int SW = $clog2(NPS),
    localparam int IW = SW + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     x_en,
    input logic [2:0]               x_mode,
    input logic [SW-1:0]            x_sel,
    input logic [AW-1:0]            x_addr,
    input logic                     y_en,
    input logic [2:0]               y_mode,
    input logic [SW-1:0]            y_sel,
    input logic [AW-1:0]            y_addr,
    input logic                     bus_wr,
    input logic [1:0]               bus_kind,
    input logic [IW-1:0]            bus_idx,
    input logic [AW-1:0]            bus_wdata,
    input logic [2*NPS-1:0][AW-1:0] ptr_all,
    input logic [2*NPS-1:0][AW-1:0] ofs_all,
    input logic [2*NPS-1:0][AW-1:0] mod_all
);
    logic [IW-1:0] xi;
    logic [IW-1:0] yi;
    logic          x_hit;
    logic          y_hit;
    logic [AW-1:0] x_m;
    logic [AW-1:0] x_msk;
    logic [AW:0]   x_step;
    logic          x_circ;

    // Flat register indices and port-write collisions per side
    always_comb begin
        xi    = {1'b0, x_sel};
        yi    = {1'b1, y_sel};
        x_hit = bus_wr && bus_kind == 2'd0 && bus_idx == xi;
        y_hit = bus_wr && bus_kind == 2'd0 && bus_idx == yi;
    end

    // Circular-buffer window of the X pointer in use
    always_comb begin
        x_m = mod_all[xi];
        for (int i = 0; i < AW; i++) begin
            x_msk[i] = (x_m >> i) != '0;
        end
        x_step = (x_mode == 3'd3 || x_mode == 3'd4) ? {1'b0, ofs_all[xi]} : (AW+1)'(1);
        x_circ = x_en && !x_hit && (x_mode >= 3'd1) && (x_mode <= 3'd4)
                 && !(&x_m) && ((x_addr & x_msk) <= x_m)
                 && (x_step <= {1'b0, x_m} + (AW+1)'(1));
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (x_en && x_mode == 3'd0 && !x_hit) |=> ptr_all[$past(xi)] == $past(x_addr));

    assert_inc_linear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_en && x_mode == 3'd1 && !x_hit && (&mod_all[xi]))
        |=> ptr_all[$past(xi)] == $past(x_addr) + AW'(1));

    assert_y_dec_linear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (y_en && y_mode == 3'd2 && !y_hit && (&mod_all[yi]))
        |=> ptr_all[$past(yi)] == $past(y_addr) - AW'(1));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_kind == 2'd0) |=> ptr_all[$past(bus_idx)] == $past(bus_wdata));

    assert_stay_in_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        x_circ |=> (((ptr_all[$past(xi)] & ~$past(x_msk)) == ($past(x_addr) & ~$past(x_msk)))
                    && ((ptr_all[$past(xi)] & $past(x_msk)) <= $past(x_m))));
endmodule

bind dual_ptr_agu agu_checker #(.AW(AW), .NPS(NPS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_en      (x_en),
    .x_mode    (x_mode),
    .x_sel     (x_sel),
    .x_addr    (x_addr),
    .y_en      (y_en),
    .y_mode    (y_mode),
    .y_sel     (y_sel),
    .y_addr    (y_addr),
    .bus_wr    (bus_wr),
    .bus_kind  (bus_kind),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .ptr_all   (ptr_all),
    .ofs_all   (ofs_all),
    .mod_all   (mod_all)
);

// File: tb/dual_ptr_agu_tb_top.sv
`timescale 1ns/1ps
module dual_ptr_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        x_en, y_en, bus_wr;
    logic [2:0]  x_mode, y_mode, bus_idx;
    logic [1:0]  x_sel, y_sel, bus_kind;
    logic [10:0] x_addr, y_addr, bus_wdata, bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int mr[8];
    int mn[8];
    int mm[8];
    int rv;

    dual_ptr_agu dut_i (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected next pointer, written from R4-R7
    function automatic int nxt_ptr(int r, int n, int m, int mode);
        int d, md, k, base, off;
        bit up, dn;
        up = (mode == 1 || mode == 3);
        dn = (mode == 2 || mode == 4);
        d  = (mode == 3 || mode == 4) ? n : 1;
        if (!up && !dn) return r;
        if (m == 2047) return (up ? r + d : r - d) & 2047;
        md = m + 1;
        k = 0;
        while ((1 << k) <= m) k++;
        base = (r >> k) << k;
        off  = r - base;
        if (up) begin
            off = off + d;
            if (off >= md) off = off - md;
        end else begin
            off = off - d;
            if (off < 0) off = off + md;
        end
        return (base + off) & 2047;
    endfunction

    task automatic idle();
        x_en = 0; y_en = 0; x_mode = 0; y_mode = 0; x_sel = 0; y_sel = 0;
        bus_wr = 0; bus_kind = 0; bus_idx = 0; bus_wdata = 0;
    endtask

    // One clock of stimulus, with address checks and model update
    task automatic cyc(bit xe, int xm, int xs, bit ye, int ym, int ys,
                       bit bw, int bk, int bi, int bd);
        int nr[8];
        x_en = xe; x_mode = 3'(xm); x_sel = 2'(xs);
        y_en = ye; y_mode = 3'(ym); y_sel = 2'(ys);
        bus_wr = bw; bus_kind = 2'(bk); bus_idx = 3'(bi); bus_wdata = 11'(bd);
        #1;
        chk("R3 x_addr", int'(x_addr), mr[xs]);
        chk("R2 y_addr", int'(y_addr), mr[4 + ys]);
        nr = mr;
        if (xe) nr[xs]     = nxt_ptr(mr[xs], mn[xs], mm[xs], xm);
        if (ye) nr[4 + ys] = nxt_ptr(mr[4 + ys], mn[4 + ys], mm[4 + ys], ym);
        if (bw) begin
            case (bk)
                0: nr[bi] = bd;
                1: mn[bi] = bd;
                2: mm[bi] = bd;
                default: ;
            endcase
        end
        mr = nr;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic rd(int kind, int idx, output int val);
        bus_wr = 0; bus_kind = 2'(kind); bus_idx = 3'(idx);
        #1;
        val = int'(bus_rdata);
    endtask

    task automatic wr(int kind, int idx, int data);
        cyc(0, 0, 0, 0, 0, 0, 1, kind, idx, data);
    endtask

    task automatic readall(string req);
        int v;
        for (int i = 0; i < 8; i++) begin
            rd(0, i, v); chk(req, v, mr[i]);
            rd(1, i, v); chk(req, v, mn[i]);
            rd(2, i, v); chk(req, v, mm[i]);
            rd(3, i, v); chk("R9 kind3 read", v, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 8; i++) begin mr[i] = 0; mn[i] = 0; mm[i] = 2047; end
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        readall("R1 reset");

        // R5: linear wrap both ways, both spaces together (R2)
        wr(0, 0, 2047);
        cyc(1, 1, 0, 1, 2, 0, 0, 0, 0, 0);
        rd(0, 0, rv); chk("R5 inc wrap", rv, 0);
        rd(0, 4, rv); chk("R5 dec wrap", rv, 2047);

        // R6: offset add/sub
        wr(1, 1, 5); wr(0, 1, 10); wr(1, 6, 3); wr(0, 6, 2);
        cyc(1, 3, 1, 1, 4, 2, 0, 0, 0, 0);
        rd(0, 1, rv); chk("R6 add N", rv, 15);
        rd(0, 6, rv); chk("R6 sub N wrap", rv, 2047);
        cyc(1, 4, 1, 0, 0, 0, 0, 0, 0, 0);
        rd(0, 1, rv); chk("R6 sub N", rv, 10);

        // R7: circular buffers, top and bottom wrap
        wr(2, 0, 9); wr(0, 0, 9);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        rd(0, 0, rv); chk("R7 top wrap", rv, 0);
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        rd(0, 0, rv); chk("R7 bottom wrap", rv, 9);
        wr(2, 5, 4); wr(0, 5, 256); wr(1, 5, 3);
        cyc(0, 0, 0, 1, 2, 1, 0, 0, 0, 0);
        rd(0, 5, rv); chk("R7 y bottom wrap", rv, 260);
        cyc(0, 0, 0, 1, 3, 1, 0, 0, 0, 0);
        rd(0, 5, rv); chk("R7 y add N wrap", rv, 258);

        // R8: port write wins over update
        wr(0, 2, 5);
        cyc(1, 1, 2, 0, 0, 0, 1, 0, 2, 100);
        rd(0, 2, rv); chk("R8 write wins", rv, 100);

        // R10: update uses old offset
        wr(1, 3, 7); wr(0, 3, 0);
        cyc(1, 3, 3, 0, 0, 0, 1, 1, 3, 3);
        rd(0, 3, rv); chk("R10 old offset", rv, 7);
        rd(1, 3, rv); chk("R10 new offset", rv, 3);

        // R9: kind 3 write ignored; R4: hold modes
        cyc(1, 0, 1, 1, 6, 3, 1, 3, 0, 55);
        cyc(0, 1, 1, 0, 2, 3, 0, 0, 0, 0);
        readall("R9 R4 after no-op");

        // Random mix
        for (int t = 0; t < 600; t++) begin
            int bk, bd, mset[6];
            mset = '{2047, 7, 9, 15, 4, 0};
            bk = $urandom_range(0, 3);
            if (bk == 1)      bd = $urandom_range(0, 20);
            else if (bk == 2) bd = mset[$urandom_range(0, 5)];
            else              bd = $urandom_range(0, 2047);
            cyc($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
                $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
                ($urandom_range(0, 3) == 0), bk, $urandom_range(0, 7), bd);
            if (t % 50 == 49) readall("R7 R6 random");
        end
        readall("R2 final");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule